// File: doc/BRIEF.md
# Reset Source Controller

This block gathers every condition that may restart the chip and turns them into a single system reset pulse. The conditions are a power-on indication, a supply comparator that is qualified by its enables and by stop mode, a reset request from the clock module, and a force-reset command. The force-reset command can only come from the debug write path. Any accepted request drives the reset output for a fixed number of cycles. A new request that arrives while the pulse is running starts the count again.

A read-only cause register tells software why the last restart happened. Every accepted request clears the cause bits and sets exactly one of them, chosen by a fixed priority. The register keeps its value through the reset pulse, and only the block's own `rst_n` clears it. The force register sits at a second address. Only the debug path can write it, and it always reads as zero. The CPU and the debug host share one write port. When both write in the same cycle, the debug write takes the port, and only a debug write carries the right to force a reset.

Top module: `rstsrc_ctrl`

## Requirements
- R1: Any accepted request makes `sys_rst_o` high from the cycle after it for exactly PULSE_CYC (16) cycles. A request accepted while the pulse runs restarts the full count.
- R2: A supply-low request exists only when `lv_below_i`, `lv_det_en_i` and `lv_rst_en_i` are all 1. With either enable at 0, a low supply causes no reset.
- R3: While `stop_mode_i` is 1, a low supply causes no reset unless `lv_stop_en_i` is 1.
- R4: The cause register (address 0, bits [2:0], upper bits read 0) is loaded with exactly one set bit on each accepted request. Bit 2 means supply-low or power-on.
- R5: Cause bit 1 means the clock-module request (`clk_mod_rst_i`).
- R6: A debug write to address 1 with data bit 0 = 1 forces a reset and sets cause bit 0. A debug write with data bit 0 = 0, or to another address, does nothing.
- R7: When several requests fall in one cycle, power-on and supply-low win over the clock module, and the clock module wins over the debug force.
- R8: CPU writes to either address cause no reset and leave the cause register unchanged.
- R9: A read of address 1, or of any address other than 0, returns 0x00.
- R10: The cause register holds its value through the reset pulse and between requests. Only `rst_n` low clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_i | input | 1 | Power-on indication |
| lv_below_i | input | 1 | Supply below trip level |
| lv_det_en_i | input | 1 | Supply detection enable |
| lv_rst_en_i | input | 1 | Supply-low reset enable |
| lv_stop_en_i | input | 1 | Keep supply detection active in stop mode |
| stop_mode_i | input | 1 | Chip is in stop mode |
| clk_mod_rst_i | input | 1 | Reset request from the clock module |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | ADDR_W | CPU address, used for reads and writes |
| cpu_wdata_i | input | DATA_W | CPU write data |
| dbg_wr_i | input | 1 | Debug write strobe |
| dbg_addr_i | input | ADDR_W | Debug write address |
| dbg_wdata_i | input | DATA_W | Debug write data |
| sys_rst_o | output | 1 | System reset pulse |
| rdata_o | output | DATA_W | Read data for `cpu_addr_i` |

## Verification
Several sources can fall in the same cycle, and the priority must then pick one cause bit. A request can also land while a pulse is already running. The bench fires the clock-module request and the debug force together, and a supply-low trip together with the clock-module request. It also raises a second request in the middle of a pulse. The cause register read back after each case must show the winning bit only, and the reset output must stay high for a full count measured from the later request. Random stimulus then overlaps all sources freely against a cycle model of the requirements.

// File: rtl/rstsrc_pkg.sv
// Shared types for the reset source controller.
// Assumes three cause bits; bit positions are fixed here.
package rstsrc_pkg;

    localparam int STAT_W     = 3;
    localparam int STAT_LVPWR = 2;
    localparam int STAT_CLK   = 1;
    localparam int STAT_DBG   = 0;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_PWRON,
        CAUSE_LV,
        CAUSE_CLK,
        CAUSE_DBG
    } cause_e;

    // Map a winning cause to its one-hot status pattern.
    function automatic logic [STAT_W-1:0] cause_bits(cause_e c);
        logic [STAT_W-1:0] b;
        b = '0;
        case (c)
            CAUSE_PWRON, CAUSE_LV: b[STAT_LVPWR] = 1'b1;
            CAUSE_CLK:             b[STAT_CLK]   = 1'b1;
            CAUSE_DBG:             b[STAT_DBG]   = 1'b1;
            default:               b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rstsrc_lv_gate.sv
// Qualifies the supply comparator with its two enables and with stop mode.
// Assumes the comparator input is already synchronous to clk.
module rstsrc_lv_gate (
    input  logic below_i,
    input  logic det_en_i,
    input  logic rst_en_i,
    input  logic stop_i,
    input  logic stop_en_i,
    output logic req_o
);
    logic det_active;

    // Detection runs outside stop, or in stop when explicitly kept alive.
    always_comb det_active = det_en_i && (!stop_i || stop_en_i);

    // Request only with reset enable set and supply below trip.
    always_comb req_o = below_i && det_active && rst_en_i;
endmodule

// File: rtl/rstsrc_wrport.sv
// Shared write port: merges CPU and debug writes and decodes the force command.
// Assumes debug wins the port on a same-cycle collision; only debug may force.
module rstsrc_wrport #(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] FORCE_ADDR = 'd1,
    parameter int                FORCE_BIT  = 0
) (
    input  logic              cpu_wr_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              dbg_wr_i,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    input  logic [DATA_W-1:0] dbg_wdata_i,
    output logic              force_o
);
    logic              wr_any;
    logic              wr_priv;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_unused;

    // Port arbitration: debug access takes the port and carries privilege.
    always_comb begin
        wr_any  = cpu_wr_i || dbg_wr_i;
        wr_priv = dbg_wr_i;
        wr_addr = dbg_wr_i ? dbg_addr_i  : cpu_addr_i;
        wr_data = dbg_wr_i ? dbg_wdata_i : cpu_wdata_i;
    end

    // Only the force bit is implemented; other data bits are dropped.
    always_comb wr_unused = ^{wr_data[DATA_W-1:FORCE_BIT+1]};

    // Force request: privileged write of 1 to the force bit.
    always_comb force_o = wr_any && wr_priv && (wr_addr == FORCE_ADDR) && wr_data[FORCE_BIT];
endmodule

// File: rtl/rstsrc_arbiter.sv
// Fixed-priority selection among reset requests.
// Order: power-on, supply-low, clock module, debug force.
module rstsrc_arbiter
    import rstsrc_pkg::*;
(
    input  logic   pwron_i,
    input  logic   lv_i,
    input  logic   clk_i,
    input  logic   dbg_i,
    output cause_e cause_o,
    output logic   accept_o
);
    // Priority chain picking the single winning cause.
    always_comb begin
        if (pwron_i)    cause_o = CAUSE_PWRON;
        else if (lv_i)  cause_o = CAUSE_LV;
        else if (clk_i) cause_o = CAUSE_CLK;
        else if (dbg_i) cause_o = CAUSE_DBG;
        else            cause_o = CAUSE_NONE;
    end

    // Any winner means the request is accepted this cycle.
    always_comb accept_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/rstsrc_stretch.sv
// Stretches an accepted request into a reset pulse of PULSE_CYC cycles.
// Assumes a new request reloads the full count.
module rstsrc_stretch #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter: reload on request, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Pulse is high while the counter is non-zero.
    always_comb active_o = (cnt_q != '0);
endmodule

// File: rtl/rstsrc_status.sv
// Cause register and read multiplexer.
// Assumes the register is read-only to software and cleared only by rst_n.
module rstsrc_status
    import rstsrc_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  cause_e            cause_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [STAT_W-1:0] status_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [STAT_W-1:0] status_q;

    // Replace all cause bits with the winner's bit on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= '0;
        else if (accept_i) status_q <= cause_bits(cause_i);
    end

    // Read mux: cause register at its address, zero everywhere else.
    always_comb begin
        rdata_o = '0;
        if (rd_addr_i == STATUS_ADDR) rdata_o[STAT_W-1:0] = status_q;
    end

    // Expose the stored cause for the checker.
    always_comb status_o = status_q;
endmodule

// File: rtl/rstsrc_ctrl.sv
// Reset source controller top: qualifies sources, picks a cause,
// stretches the reset pulse and records the cause.
// Assumes all inputs are synchronous to clk.
module rstsrc_ctrl
    import rstsrc_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                PULSE_CYC   = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd0,
    parameter logic [ADDR_W-1:0] FORCE_ADDR  = 'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              lv_below_i,
    input  logic              lv_det_en_i,
    input  logic              lv_rst_en_i,
    input  logic              lv_stop_en_i,
    input  logic              stop_mode_i,
    input  logic              clk_mod_rst_i,
    input  logic              cpu_wr_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              dbg_wr_i,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    input  logic [DATA_W-1:0] dbg_wdata_i,
    output logic              sys_rst_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              lv_req_w;
    logic              force_w;
    logic              accept_w;
    cause_e            cause_w;
    logic [STAT_W-1:0] status_w;

    rstsrc_lv_gate u_lv (
        .below_i  (lv_below_i),
        .det_en_i (lv_det_en_i),
        .rst_en_i (lv_rst_en_i),
        .stop_i   (stop_mode_i),
        .stop_en_i(lv_stop_en_i),
        .req_o    (lv_req_w)
    );

    rstsrc_wrport #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FORCE_ADDR(FORCE_ADDR),
        .FORCE_BIT (0)
    ) u_wr (
        .cpu_wr_i   (cpu_wr_i),
        .cpu_addr_i (cpu_addr_i),
        .cpu_wdata_i(cpu_wdata_i),
        .dbg_wr_i   (dbg_wr_i),
        .dbg_addr_i (dbg_addr_i),
        .dbg_wdata_i(dbg_wdata_i),
        .force_o    (force_w)
    );

    rstsrc_arbiter u_arb (
        .pwron_i (por_i),
        .lv_i    (lv_req_w),
        .clk_i   (clk_mod_rst_i),
        .dbg_i   (force_w),
        .cause_o (cause_w),
        .accept_o(accept_w)
    );

    rstsrc_stretch #(
        .PULSE_CYC(PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept_w),
        .active_o(sys_rst_o)
    );

    rstsrc_status #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STATUS_ADDR(STATUS_ADDR)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept_w),
        .cause_i  (cause_w),
        .rd_addr_i(cpu_addr_i),
        .status_o (status_w),
        .rdata_o  (rdata_o)
    );
endmodule

// File: rtl/rstsrc_ctrl_chk.sv
// Property checker for rstsrc_ctrl, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module rstsrc_ctrl_chk #(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                PULSE_CYC   = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd0,
    parameter logic [ADDR_W-1:0] FORCE_ADDR  = 'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_i,
    input logic              lv_below_i,
    input logic              lv_det_en_i,
    input logic              lv_rst_en_i,
    input logic              lv_stop_en_i,
    input logic              stop_mode_i,
    input logic              clk_mod_rst_i,
    input logic              dbg_wr_i,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic              sys_rst_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              accept_i,
    input logic [2:0]        status_i
);
    localparam int SW = $clog2(PULSE_CYC + 2) + 1;
    localparam logic [SW-1:0] SMAX = {SW{1'b1}};

    logic [SW-1:0] since_q;

    // Cycles since the last accepted request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)           since_q <= '0;
        else if (accept_i)    since_q <= '0;
        else if (since_q != SMAX) since_q <= since_q + 1'b1;
    end

    // R1: power-on always raises the reset next cycle.
    p_pulse_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> sys_rst_o);

    // R1: the pulse ends exactly PULSE_CYC cycles after the last request.
    p_pulse_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (since_q == SW'(PULSE_CYC)));

    // R2, R3, R8: with no qualified source, an idle output stays idle.
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_o && !por_i && !clk_mod_rst_i && !dbg_wr_i &&
         !(lv_below_i && lv_det_en_i && lv_rst_en_i && (!stop_mode_i || lv_stop_en_i)))
        |=> !sys_rst_o);

    // R4: at most one cause bit is ever set.
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_i));

    // R5: a lone clock-module request records bit 1.
    p_clk_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mod_rst_i && !por_i && !lv_below_i) |=> (status_i == 3'b010));

    // R7: power-on beats everything and records bit 2.
    p_pwron_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (status_i == 3'b100));

    // R9: the force register always reads zero.
    p_force_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_i == FORCE_ADDR) |-> (rdata_o == '0));

    // R10: without an accepted request the cause register is stable.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(status_i));

    // R4: the status address returns the cause register.
    p_status_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_i == STATUS_ADDR) |-> (rdata_o == DATA_W'(status_i)));
endmodule

bind rstsrc_ctrl rstsrc_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .STATUS_ADDR(STATUS_ADDR),
    .FORCE_ADDR (FORCE_ADDR)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_i        (por_i),
    .lv_below_i   (lv_below_i),
    .lv_det_en_i  (lv_det_en_i),
    .lv_rst_en_i  (lv_rst_en_i),
    .lv_stop_en_i (lv_stop_en_i),
    .stop_mode_i  (stop_mode_i),
    .clk_mod_rst_i(clk_mod_rst_i),
    .dbg_wr_i     (dbg_wr_i),
    .cpu_addr_i   (cpu_addr_i),
    .sys_rst_o    (sys_rst_o),
    .rdata_o      (rdata_o),
    .accept_i     (accept_w),
    .status_i     (status_w)
);

// File: tb/rstsrc_ctrl_tb.sv
// Self-checking bench for rstsrc_ctrl: directed corners plus seeded random.
module rstsrc_ctrl_tb_top;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       por_i, lv_below_i, lv_det_en_i, lv_rst_en_i, lv_stop_en_i;
    logic       stop_mode_i, clk_mod_rst_i, cpu_wr_i, dbg_wr_i;
    logic [3:0] cpu_addr_i, dbg_addr_i;
    logic [7:0] cpu_wdata_i, dbg_wdata_i;
    logic       sys_rst_o;
    logic [7:0] rdata_o;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    int         m_cnt = 0;
    logic [2:0] m_stat = 3'b000;

    always #2 clk = ~clk;

    rstsrc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .lv_below_i(lv_below_i),
        .lv_det_en_i(lv_det_en_i), .lv_rst_en_i(lv_rst_en_i),
        .lv_stop_en_i(lv_stop_en_i), .stop_mode_i(stop_mode_i),
        .clk_mod_rst_i(clk_mod_rst_i), .cpu_wr_i(cpu_wr_i),
        .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .dbg_wr_i(dbg_wr_i), .dbg_addr_i(dbg_addr_i), .dbg_wdata_i(dbg_wdata_i),
        .sys_rst_o(sys_rst_o), .rdata_o(rdata_o)
    );

    // R2/R3 reference: qualified supply-low request.
    function automatic logic lv_req(logic b, logic d, logic e, logic s, logic se);
        return b && d && e && (!s || se);
    endfunction

    // R4..R7 reference: winning cause pattern, 0 if none.
    function automatic logic [2:0] exp_bits(logic pw, logic lv, logic ck, logic dg);
        if (pw || lv) return 3'b100;
        if (ck)       return 3'b010;
        if (dg)       return 3'b001;
        return 3'b000;
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        por_i = 0; lv_below_i = 0; clk_mod_rst_i = 0;
        cpu_wr_i = 0; dbg_wr_i = 0; cpu_wdata_i = 0; dbg_wdata_i = 0; dbg_addr_i = 0;
    endtask

    // One clock: advance the model with the driven inputs, then compare.
    task automatic cyc(string tag);
        logic [2:0] b;
        b = exp_bits(por_i,
                     lv_req(lv_below_i, lv_det_en_i, lv_rst_en_i, stop_mode_i, lv_stop_en_i),
                     clk_mod_rst_i,
                     dbg_wr_i && (dbg_addr_i == 4'd1) && dbg_wdata_i[0]);
        @(posedge clk);
        if (!rst_n) begin m_cnt = 0; m_stat = 3'b000; end
        else if (b != 3'b000) begin m_cnt = PULSE; m_stat = b; end
        else if (m_cnt > 0) m_cnt--;
        @(negedge clk);
        chk(tag, "sys_rst", {7'b0, sys_rst_o}, {7'b0, m_cnt != 0});
        chk(tag, "rdata", rdata_o, (cpu_addr_i == 4'd0) ? {5'b0, m_stat} : 8'h00);
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7319));
        idle();
        rst_n = 0; lv_det_en_i = 1; lv_rst_en_i = 1; lv_stop_en_i = 0;
        stop_mode_i = 0; cpu_addr_i = 4'd0;
        @(negedge clk);
        run("R10", 3);                       // reset state: cause cleared, no pulse
        rst_n = 1;
        run("R10", 2);

        por_i = 1; cyc("R1"); idle();        // power-on pulse length
        run("R1", 20);
        cpu_addr_i = 4'd0; cyc("R4");        // cause bit 2

        clk_mod_rst_i = 1; cyc("R5"); idle();
        run("R10", 8);                       // cause held mid-pulse
        clk_mod_rst_i = 1; cyc("R1"); idle(); // restart mid-pulse
        run("R1", 20);

        lv_det_en_i = 1; lv_rst_en_i = 0; lv_below_i = 1; run("R2", 3); idle();
        lv_det_en_i = 0; lv_rst_en_i = 1; lv_below_i = 1; run("R2", 3); idle();
        lv_det_en_i = 1; lv_below_i = 1; cyc("R2"); idle(); run("R2", 18);

        stop_mode_i = 1; lv_stop_en_i = 0; lv_below_i = 1; run("R3", 3); idle();
        lv_stop_en_i = 1; lv_below_i = 1; cyc("R3"); idle(); run("R3", 18);
        stop_mode_i = 0; lv_stop_en_i = 0;

        dbg_wr_i = 1; dbg_addr_i = 4'd1; dbg_wdata_i = 8'h01; cyc("R6"); idle();
        run("R6", 18);
        dbg_wr_i = 1; dbg_addr_i = 4'd1; dbg_wdata_i = 8'hFE; run("R6", 2); idle();
        dbg_wr_i = 1; dbg_addr_i = 4'd0; dbg_wdata_i = 8'hFF; run("R6", 2); idle();

        cpu_wr_i = 1; cpu_addr_i = 4'd1; cpu_wdata_i = 8'hFF; run("R8", 3); idle();
        cpu_wr_i = 1; cpu_addr_i = 4'd0; cpu_wdata_i = 8'hFF; run("R8", 3); idle();
        cpu_addr_i = 4'd1; run("R9", 2);
        cpu_addr_i = 4'd7; run("R9", 2);
        cpu_addr_i = 4'd0;

        clk_mod_rst_i = 1; dbg_wr_i = 1; dbg_addr_i = 4'd1; dbg_wdata_i = 8'h01;
        cyc("R7"); idle(); run("R7", 18);
        clk_mod_rst_i = 1; lv_below_i = 1; cyc("R7"); idle(); run("R7", 18);
        por_i = 1; clk_mod_rst_i = 1; cyc("R7"); idle(); run("R7", 18);

        for (int i = 0; i < 3000; i++) begin
            por_i         = ($urandom_range(0, 199) == 0);
            clk_mod_rst_i = ($urandom_range(0, 59) == 0);
            lv_below_i    = ($urandom_range(0, 19) == 0);
            lv_det_en_i   = 1'($urandom_range(0, 1));
            lv_rst_en_i   = 1'($urandom_range(0, 1));
            lv_stop_en_i  = 1'($urandom_range(0, 1));
            stop_mode_i   = ($urandom_range(0, 3) == 0);
            dbg_wr_i      = ($urandom_range(0, 39) == 0);
            dbg_addr_i    = 4'($urandom_range(0, 3));
            dbg_wdata_i   = 8'($urandom);
            cpu_wr_i      = ($urandom_range(0, 3) == 0);
            cpu_addr_i    = 4'($urandom_range(0, 3));
            cpu_wdata_i   = 8'($urandom);
            cyc("R4");
        end
        idle();
        run("R1", 20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule